// File: doc/BRIEF.md
# Audio Frame Sync Generator

This block is the timing master of an audio serial port. A per-cycle bit tick advances a frame counter. The tick comes either from an internal bit-clock enable or from rising edges of an external bit clock pin, for use when the codec supplies the bit clock. A configuration word holds the frame length and the sync pulse length, each written as the count minus one. The block drives a frame sync line whose active level is selectable. It also sends a one-cycle frame-start strobe to the transmit and receive shifters.

The counter and the frame sync have their own enables, and software turns them on in that order. Bit 28 of the configuration word chooses the frame source. When it is set, the frame counter wraps freely. When it is clear, each frame is started by a data transfer request. The power-on configuration constant describes two 16-bit samples per frame.

Top module: `afsg_frame_sync_gen`

## Requirements
- R1: While reset is asserted, `bit_count` is 0, `frame_start` is 0 and `fsync` sits at its inactive level: 0 when `fs_active_low` is 0, and 1 when it is 1.
- R2: In counter mode (cfg bit 28 = 1) with `gen_enable` high, the first tick after enabling sets `bit_count` to 0. Each later tick adds one, and a tick at the period value P (cfg bits 27:16) wraps the count to 0, so a frame lasts P+1 ticks.
- R3: With both enables high, the sync is active for counts 0 through W inclusive, where W is cfg bits 15:8. `fsync` changes in the same cycle as `bit_count`.
- R4: `frame_start` is high for exactly the one cycle in which `bit_count` has just become 0 at the start of a frame. It only pulses when both enables are high.
- R5: With `fs_active_low` = 1 the active sync level is 0; with 0 it is 1.
- R6: While `gen_enable` is low, setting `fs_enable` has no effect: the count stays 0, `fsync` stays inactive and `frame_start` stays 0. While `fs_enable` is low, the counter still runs but `fsync` stays inactive and no strobe appears.
- R7: One cycle after `gen_enable` falls, `bit_count` is 0 and `fsync` is inactive.
- R8: A cycle without a tick leaves `bit_count` unchanged.
- R9: In transfer mode (cfg bit 28 = 0), the count sits at 0 with the sync inactive until a tick arrives together with `xfer_req`. Such a tick starts a frame at count 0. The count then climbs by one per tick up to P and holds there with the sync inactive until the next request.
- R10: With `ext_clk_sel` = 1, ticks come only from rising edges of `ext_bclk` after a two-stage synchronizer, and `bclk_ce` is ignored. The count moves once per external rising edge, two cycles after the first clock edge that samples the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Generator configuration: [27:16] period-1, [15:8] width-1, [28] counter-driven frame |
| fs_active_low | input | 1 | 1 makes the frame sync active low |
| gen_enable | input | 1 | Counter enable, set first |
| fs_enable | input | 1 | Frame sync enable, set after the counter enable |
| ext_clk_sel | input | 1 | 1 takes ticks from the external bit clock pin |
| bclk_ce | input | 1 | Internal bit-clock enable, one tick per high cycle |
| ext_bclk | input | 1 | External bit clock pin (asynchronous) |
| xfer_req | input | 1 | Data transfer request, starts a frame in transfer mode |
| fsync | output | 1 | Frame sync line at the selected polarity |
| frame_start | output | 1 | One-cycle strobe at count 0 for the shifters |
| bit_tick | output | 1 | The selected bit tick |
| bit_count | output | 12 | Current position in the frame |

## Verification
The count, the sync and the strobe are registered together. All three show the effect of an internal tick, an enable change or a request right after the one clock edge that samples it. The bench changes inputs on falling edges and compares every output on the falling edge that follows, against counts computed as tick number modulo P+1. An external clock edge takes two more cycles through the synchronizer and edge detector. For that case the bench holds each pin level for three cycles and checks only once the level has settled. Pulses of the frame-start strobe are checked in every cycle of the internal-tick runs.

// File: rtl/afsg_pkg.sv
package afsg_pkg;
    localparam int CFG_W       = 32;
    localparam int PER_LSB     = 16;
    localparam int PER_W       = 12;
    localparam int WID_LSB     = 8;
    localparam int WID_W       = 8;
    localparam int SRC_BIT     = 28;
    localparam int SYNC_STAGES = 2;

    // two 16-bit samples per frame, frame driven by the counter
    localparam logic [CFG_W-1:0] CFG_DEFAULT =
        (CFG_W'(1) << SRC_BIT) | (CFG_W'(31) << PER_LSB) | (CFG_W'(15) << WID_LSB);

    typedef struct packed {
        logic             from_counter;
        logic [PER_W-1:0] period;
        logic [WID_W-1:0] width;
    } gen_cfg_t;

    function automatic gen_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
        gen_cfg_t c;
        c.from_counter = w[SRC_BIT];
        c.period       = w[PER_LSB +: PER_W];
        c.width        = w[WID_LSB +: WID_W];
        return c;
    endfunction
endpackage

// File: rtl/afsg_tick_sel.sv
module afsg_tick_sel #(
    parameter int STAGES = afsg_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_sel,
    input  logic int_ce,
    input  logic ext_pin,
    output logic tick_o
);
    localparam int SH_W = STAGES + 1;

    typedef struct packed {
        logic [SH_W-1:0] sh;
    } tick_state_t;

    tick_state_t cur_q, nxt_d;
    logic        ext_edge;

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.sh = {cur_q.sh[SH_W-2:0], ext_pin};
        ext_edge = cur_q.sh[STAGES-1] & ~cur_q.sh[STAGES];
        tick_o   = ext_sel ? ext_edge : int_ce;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // R10
    ext_tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sel && tick_o) |=> (!tick_o || !ext_sel));
endmodule

// File: rtl/afsg_frame_ctr.sv
module afsg_frame_ctr #(
    parameter int CNT_W = afsg_pkg::PER_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en,
    input  logic             tick,
    input  logic             from_counter,
    input  logic             xfer_req,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic [CNT_W-1:0] cnt_next_o,
    output logic             live_next_o,
    output logic             wrap_next_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             live;
    } ctr_state_t;

    ctr_state_t cur_q, nxt_d;
    logic       wrap_d;

    always_comb begin
        nxt_d  = cur_q;
        wrap_d = 1'b0;
        if (!gen_en) begin
            nxt_d.cnt  = '0;
            nxt_d.live = 1'b0;
        end else if (tick) begin
            if (from_counter) begin
                if (!cur_q.live || cur_q.cnt >= period) begin
                    nxt_d.cnt  = '0;
                    nxt_d.live = 1'b1;
                    wrap_d     = 1'b1;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end else begin
                if (xfer_req) begin
                    nxt_d.cnt  = '0;
                    nxt_d.live = 1'b1;
                    wrap_d     = 1'b1;
                end else if (cur_q.live && cur_q.cnt < period) begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end else begin
                    nxt_d.live = 1'b0;
                end
            end
        end
        cnt_q_o     = cur_q.cnt;
        cnt_next_o  = nxt_d.cnt;
        live_next_o = nxt_d.live;
        wrap_next_o = wrap_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && tick && from_counter && cur_q.live && cur_q.cnt < period)
        |=> cur_q.cnt == $past(cur_q.cnt) + 1'b1);
    // R8
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && !tick) |=> $stable(cur_q.cnt));
    // R7
    gen_off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> (cur_q.cnt == '0 && !cur_q.live));
    // R9
    xfer_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && tick && !from_counter && xfer_req) |=> (cur_q.cnt == '0 && cur_q.live));
endmodule

// File: rtl/afsg_fsync_out.sv
module afsg_fsync_out #(
    parameter int CNT_W = afsg_pkg::PER_W,
    parameter int WID_W = afsg_pkg::WID_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en,
    input  logic             fs_en,
    input  logic             active_low,
    input  logic [WID_W-1:0] width,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic             live_next,
    input  logic             wrap_next,
    output logic             fsync_o,
    output logic             fstart_o
);
    typedef struct packed {
        logic act;
        logic fstart;
    } out_state_t;

    out_state_t       cur_q, nxt_d;
    logic [CNT_W-1:0] width_ext;
    logic             both_en;

    always_comb begin
        width_ext    = CNT_W'(width);
        both_en      = gen_en & fs_en;
        nxt_d.act    = both_en & live_next & (cnt_next <= width_ext);
        nxt_d.fstart = both_en & wrap_next;
        fsync_o      = cur_q.act ^ active_low;
        fstart_o     = cur_q.fstart;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // R6
    staged_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_en || !fs_en) |=> (!cur_q.act && !cur_q.fstart));
endmodule

// File: rtl/afsg_frame_sync_gen.sv
module afsg_frame_sync_gen
    import afsg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             fs_active_low,
    input  logic             gen_enable,
    input  logic             fs_enable,
    input  logic             ext_clk_sel,
    input  logic             bclk_ce,
    input  logic             ext_bclk,
    input  logic             xfer_req,
    output logic             fsync,
    output logic             frame_start,
    output logic             bit_tick,
    output logic [PER_W-1:0] bit_count
);
    gen_cfg_t         cfg;
    logic [PER_W-1:0] cnt_next;
    logic             live_next;
    logic             wrap_next;

    always_comb cfg = decode_cfg(cfg_word);

    afsg_tick_sel #(.STAGES(SYNC_STAGES)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_sel (ext_clk_sel),
        .int_ce  (bclk_ce),
        .ext_pin (ext_bclk),
        .tick_o  (bit_tick)
    );

    afsg_frame_ctr #(.CNT_W(PER_W)) u_ctr (
        .clk          (clk),
        .rst_n        (rst_n),
        .gen_en       (gen_enable),
        .tick         (bit_tick),
        .from_counter (cfg.from_counter),
        .xfer_req     (xfer_req),
        .period       (cfg.period),
        .cnt_q_o      (bit_count),
        .cnt_next_o   (cnt_next),
        .live_next_o  (live_next),
        .wrap_next_o  (wrap_next)
    );

    afsg_fsync_out #(.CNT_W(PER_W), .WID_W(WID_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .gen_en     (gen_enable),
        .fs_en      (fs_enable),
        .active_low (fs_active_low),
        .width      (cfg.width),
        .cnt_next   (cnt_next),
        .live_next  (live_next),
        .wrap_next  (wrap_next),
        .fsync_o    (fsync),
        .fstart_o   (frame_start)
    );

    // R4
    fstart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> bit_count == '0);
    // R3
    fstart_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> fsync != fs_active_low);
endmodule

// File: tb/afsg_frame_sync_gen_tb.sv
module afsg_frame_sync_gen_tb;
    import afsg_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CFG_W-1:0] cfg_word = CFG_DEFAULT;
    logic             fs_active_low = 1'b0;
    logic             gen_enable = 1'b0;
    logic             fs_enable = 1'b0;
    logic             ext_clk_sel = 1'b0;
    logic             bclk_ce = 1'b0;
    logic             ext_bclk = 1'b0;
    logic             xfer_req = 1'b0;
    logic             fsync;
    logic             frame_start;
    logic             bit_tick;
    logic [PER_W-1:0] bit_count;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    afsg_frame_sync_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .fs_active_low(fs_active_low),
        .gen_enable(gen_enable), .fs_enable(fs_enable), .ext_clk_sel(ext_clk_sel),
        .bclk_ce(bclk_ce), .ext_bclk(ext_bclk), .xfer_req(xfer_req),
        .fsync(fsync), .frame_start(frame_start), .bit_tick(bit_tick), .bit_count(bit_count)
    );

    function automatic logic [CFG_W-1:0] mk_cfg(input int src, input int per, input int wid);
        return (CFG_W'(src) << SRC_BIT) | (CFG_W'(per) << PER_LSB) | (CFG_W'(wid) << WID_LSB);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic shut_off();
        gen_enable = 1'b0;
        fs_enable  = 1'b0;
        xfer_req   = 1'b0;
        step();
    endtask

    task automatic run_counter(input int p, input int w, input int pol, input int ncyc);
        shut_off();
        cfg_word      = mk_cfg(1, p, w);
        fs_active_low = pol[0];
        bclk_ce       = 1'b1;
        gen_enable    = 1'b1;
        fs_enable     = 1'b1;
        for (int j = 0; j < ncyc; j++) begin
            int c;
            step();
            c = j % (p + 1);
            chk("R2 count", int'(bit_count), c);
            chk("R3/R5 fsync", int'(fsync), int'((c <= w) ^ pol[0]));
            chk("R4 frame_start", int'(frame_start), int'(c == 0));
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int ticks;
        // R1 reset state for both polarities
        repeat (2) @(negedge clk);
        chk("R1 count", int'(bit_count), 0);
        chk("R1 fsync high-active idle", int'(fsync), 0);
        chk("R1 frame_start", int'(frame_start), 0);
        fs_active_low = 1'b1;
        #1;
        chk("R1 fsync low-active idle", int'(fsync), 1);
        @(negedge clk);
        rst_n = 1'b1;
        step();

        // R2 R3 R4 R5 sweep of small periods and widths
        for (int p = 1; p <= 6; p++) begin
            for (int w = 0; w <= p; w++) begin
                run_counter(p, w, (p + w) % 2, 2 * (p + 1) + 1);
            end
        end

        // R2 R5 default configuration with low-active sync
        shut_off();
        cfg_word      = CFG_DEFAULT;
        fs_active_low = 1'b1;
        gen_enable    = 1'b1;
        fs_enable     = 1'b1;
        for (int j = 0; j < 70; j++) begin
            step();
            chk("R2 default count", int'(bit_count), j % 32);
            chk("R5 default fsync", int'(fsync), int'(!((j % 32) <= 15)));
        end

        // R8 gaps in the tick
        shut_off();
        cfg_word      = mk_cfg(1, 4, 1);
        fs_active_low = 1'b0;
        gen_enable    = 1'b1;
        fs_enable     = 1'b1;
        ticks = 0;
        for (int j = 0; j < 30; j++) begin
            int c;
            bclk_ce = (j % 3 != 2);
            step();
            if (j % 3 != 2) ticks++;
            c = (ticks - 1) % 5;
            chk("R8 count", int'(bit_count), c);
            chk("R8 fsync", int'(fsync), int'(c <= 1));
            chk("R8 frame_start", int'(frame_start), int'((j % 3 != 2) && c == 0));
        end
        bclk_ce = 1'b1;

        // R7 disabling the counter
        gen_enable = 1'b0;
        step();
        chk("R7 count", int'(bit_count), 0);
        chk("R7 fsync", int'(fsync), 0);
        chk("R7 frame_start", int'(frame_start), 0);

        // R6 sync enable before counter enable
        fs_enable = 1'b1;
        for (int j = 0; j < 5; j++) begin
            step();
            chk("R6 count", int'(bit_count), 0);
            chk("R6 fsync", int'(fsync), 0);
            chk("R6 frame_start", int'(frame_start), 0);
        end
        shut_off();
        cfg_word   = mk_cfg(1, 5, 2);
        gen_enable = 1'b1;
        for (int j = 0; j < 21; j++) begin
            int c;
            fs_enable = (j >= 9);
            step();
            c = j % 6;
            chk("R6 staged count", int'(bit_count), c);
            chk("R6 staged fsync", int'(fsync), int'((j >= 9) && c <= 2));
            chk("R6 staged frame_start", int'(frame_start), int'((j >= 9) && c == 0));
        end

        // R9 transfer-driven frames
        shut_off();
        cfg_word   = mk_cfg(0, 7, 2);
        gen_enable = 1'b1;
        fs_enable  = 1'b1;
        for (int j = 0; j < 5; j++) begin
            step();
            chk("R9 idle count", int'(bit_count), 0);
            chk("R9 idle fsync", int'(fsync), 0);
            chk("R9 idle frame_start", int'(frame_start), 0);
        end
        for (int r = 0; r < 2; r++) begin
            for (int k = 0; k < 12; k++) begin
                int c;
                xfer_req = (k == 0);
                step();
                c = (k < 7) ? k : 7;
                chk("R9 count", int'(bit_count), c);
                chk("R9 fsync", int'(fsync), int'(k <= 2));
                chk("R9 frame_start", int'(frame_start), int'(k == 0));
            end
        end
        xfer_req = 1'b0;

        // R10 external bit clock
        shut_off();
        cfg_word    = mk_cfg(1, 3, 1);
        ext_clk_sel = 1'b1;
        bclk_ce     = 1'b1;
        ext_bclk    = 1'b0;
        gen_enable  = 1'b1;
        fs_enable   = 1'b1;
        repeat (4) step();
        chk("R10 no edge count", int'(bit_count), 0);
        chk("R10 no edge fsync", int'(fsync), 0);
        for (int e = 0; e < 10; e++) begin
            ext_bclk = 1'b1;
            repeat (3) step();
            ext_bclk = 1'b0;
            repeat (3) step();
            chk("R10 count", int'(bit_count), e % 4);
            chk("R10 fsync", int'(fsync), int'((e % 4) <= 1));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule